// File: doc/BRIEF.md
# On-screen character overlay generator

This block produces a one-bit overlay signal that a downstream video path mixes onto a composite picture to show text. The text comes from a small display memory with one 6-bit character code per screen position. The block reads that memory through a read port it drives itself. It turns each code into dots using a glyph table that it computes internally. The result leaves the block serially, one dot per cycle of the local dot clock. The dot clock runs at roughly 6 MHz, so its rate sets how wide the characters look on screen.

The block has no free-running frame timing of its own. It takes horizontal and vertical sync from the incoming video, brings each into the dot-clock domain, and restarts its counters on their rising edges. Sixty positions are shown as two text rows of thirty characters. The text area starts at a fixed dot column after each line sync and at a fixed line after each field sync. Each character cell is 6 dots by 8 lines and holds a 5 by 7 glyph.

Top module: `osd_overlay_gen`

## Requirements
- R1: While rst_n is low, and afterwards until the first sync edge has been seen, ovl_out is 0 and mem_rd_addr is 0.
- R2: hsync_in and vsync_in are active high and each passes through two flops. Suppose hsync_in is first sampled high at clock edge k. The dot at horizontal position x (x = 0, 1, ...) then appears on ovl_out after edge k+3+x. A vsync rising edge, handled the same way, makes the following line line 0. Each later hsync rising edge advances the line by one. When both edges arrive in the same cycle, the vsync edge wins.
- R3: A rising edge on hsync_in part way through a line restarts the dot position at 0, whatever position had been reached.
- R4: Inside the text window, mem_rd_addr = row*30 + col. Here col = (x-64)/6 and row = (y-40)/8, with x the dot position and y the line. Outside the window, mem_rd_addr is 0.
- R5: For a code c below 44 and a glyph line l from 0 to 6, the five glyph dots are the low 5 bits of (13*c + 3*l*l + 5). The leftmost dot is bit 4. The dot within a cell is d = (x-64) mod 6 and the line within a cell is l = (y-40) mod 8.
- R6: Cell dot column 5 and cell line 7 are always blank.
- R7: Codes 44 to 63 produce no dots anywhere in their cell.
- R8: ovl_out is 0 outside the window, which covers dot positions 64 to 243 and lines 40 to 55.
- R9: The dot and line positions stop at their maximum values, 1023 and 511, instead of wrapping. A line with no hsync edge for that long therefore shows nothing beyond the window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Dot clock, about 6 MHz |
| rst_n | input | 1 | Asynchronous active-low reset, deasserted synchronously |
| hsync_in | input | 1 | Horizontal sync from the video signal, asynchronous, active high |
| vsync_in | input | 1 | Vertical sync from the video signal, asynchronous, active high |
| mem_rd_addr | output | 6 | Display memory position being read |
| mem_rd_data | input | 6 | Character code at mem_rd_addr, combinational read |
| ovl_out | output | 1 | Overlay dot, high where a character dot is drawn |

## Verification
The assertions assume that the display memory returns the code for mem_rd_addr in the same cycle. They also assume that each sync pulse is high for at least two dot clocks, so the two-flop synchronizer sees each pulse exactly once. The stimulus drives both syncs on the falling clock edge and holds every hsync pulse for 20 dots, with vsync covering three whole lines. It rewrites the memory only while the raster is below the text window. The irregular cases are a line cut short by an early hsync and a line stretched past the counter limit. These keep to the same pulse rules.

// File: rtl/osd_pkg.sv
package osd_pkg;
  localparam int CODE_W     = 6;
  localparam int GLYPH_W    = 5;
  localparam int GLYPH_H    = 7;
  localparam int CELL_W     = 6;
  localparam int CELL_H     = 8;
  localparam int NUM_GLYPHS = 44;
  localparam int DOT_W      = $clog2(CELL_W);
  localparam int LINE_W     = $clog2(CELL_H);

  // Computed glyph row: low bits of 13*c + 3*l*l + 5, leftmost dot in MSB
  function automatic logic [GLYPH_W-1:0] glyph_row(input logic [CODE_W-1:0] code,
                                                    input logic [LINE_W-1:0] line);
    logic [7:0] acc;
    acc = 8'(code) * 8'd13 + 8'(line) * 8'(line) * 8'd3 + 8'd5;
    return acc[GLYPH_W-1:0];
  endfunction
endpackage

// File: rtl/osd_sync_edge.sv
module osd_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic lead
);
  logic [STAGES-1:0] chain_q, chain_nxt;
  logic              prev_q;

  always_comb begin
    chain_nxt = {chain_q[STAGES-2:0], async_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
      prev_q  <= 1'b0;
    end else begin
      chain_q <= chain_nxt;
      prev_q  <= chain_q[STAGES-1];
    end
  end

  assign lead = chain_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/osd_raster.sv
module osd_raster #(
  parameter int H_W = 10,
  parameter int V_W = 9
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           h_lead,
  input  logic           v_lead,
  output logic [H_W-1:0] h_cnt,
  output logic [V_W-1:0] v_cnt
);
  localparam logic [H_W-1:0] H_MAX = '1;
  localparam logic [V_W-1:0] V_MAX = '1;

  logic [H_W-1:0] h_nxt;
  logic [V_W-1:0] v_nxt;
  logic           v_en;

  always_comb begin
    if (h_lead)              h_nxt = '0;
    else if (h_cnt == H_MAX) h_nxt = h_cnt;
    else                     h_nxt = h_cnt + 1'b1;

    v_en = h_lead | v_lead;
    if (v_lead)              v_nxt = '0;
    else if (v_cnt == V_MAX) v_nxt = v_cnt;
    else                     v_nxt = v_cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) h_cnt <= H_MAX;
    else        h_cnt <= h_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    v_cnt <= V_MAX;
    else if (v_en) v_cnt <= v_nxt;
  end
endmodule

// File: rtl/osd_cell_map.sv
module osd_cell_map
  import osd_pkg::*;
#(
  parameter int H_W        = 10,
  parameter int V_W        = 9,
  parameter int ROWS       = 2,
  parameter int COLS       = 30,
  parameter int START_COL  = 64,
  parameter int START_LINE = 40,
  parameter int ADDR_W     = 6
) (
  input  logic [H_W-1:0]    h_cnt,
  input  logic [V_W-1:0]    v_cnt,
  output logic              active,
  output logic [ADDR_W-1:0] addr,
  output logic [DOT_W-1:0]  dot,
  output logic [LINE_W-1:0] line
);
  localparam int X_END = START_COL + COLS * CELL_W;
  localparam int Y_END = START_LINE + ROWS * CELL_H;

  logic           in_x, in_y;
  logic [H_W-1:0] rel_x, col, dot_w;
  logic [V_W-1:0] rel_y, row, line_w;

  always_comb begin
    in_x   = (h_cnt >= H_W'(START_COL)) && (h_cnt < H_W'(X_END));
    in_y   = (v_cnt >= V_W'(START_LINE)) && (v_cnt < V_W'(Y_END));
    rel_x  = h_cnt - H_W'(START_COL);
    rel_y  = v_cnt - V_W'(START_LINE);
    col    = rel_x / H_W'(CELL_W);
    dot_w  = rel_x % H_W'(CELL_W);
    row    = rel_y / V_W'(CELL_H);
    line_w = rel_y % V_W'(CELL_H);
    active = in_x && in_y;
    dot    = DOT_W'(dot_w);
    line   = LINE_W'(line_w);
    if (active) addr = ADDR_W'(row) * ADDR_W'(COLS) + ADDR_W'(col);
    else        addr = '0;
  end
endmodule

// File: rtl/osd_overlay_gen.sv
module osd_overlay_gen
  import osd_pkg::*;
#(
  parameter int ROWS       = 2,
  parameter int COLS       = 30,
  parameter int START_COL  = 64,
  parameter int START_LINE = 40,
  parameter int H_W        = 10,
  parameter int V_W        = 9,
  parameter int ADDR_W     = $clog2(ROWS * COLS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hsync_in,
  input  logic              vsync_in,
  output logic [ADDR_W-1:0] mem_rd_addr,
  input  logic [CODE_W-1:0] mem_rd_data,
  output logic              ovl_out
);
  logic              h_lead, v_lead;
  logic [H_W-1:0]    h_cnt;
  logic [V_W-1:0]    v_cnt;
  logic              active;
  logic [DOT_W-1:0]  dot;
  logic [LINE_W-1:0] line;
  logic [GLYPH_W-1:0] row_bits;
  logic              pix_nxt, ovl_q;

  osd_sync_edge #(.STAGES(2)) u_hsync (
    .clk(clk), .rst_n(rst_n), .async_in(hsync_in), .lead(h_lead));

  osd_sync_edge #(.STAGES(2)) u_vsync (
    .clk(clk), .rst_n(rst_n), .async_in(vsync_in), .lead(v_lead));

  osd_raster #(.H_W(H_W), .V_W(V_W)) u_raster (
    .clk(clk), .rst_n(rst_n), .h_lead(h_lead), .v_lead(v_lead),
    .h_cnt(h_cnt), .v_cnt(v_cnt));

  osd_cell_map #(
    .H_W(H_W), .V_W(V_W), .ROWS(ROWS), .COLS(COLS),
    .START_COL(START_COL), .START_LINE(START_LINE), .ADDR_W(ADDR_W)
  ) u_map (
    .h_cnt(h_cnt), .v_cnt(v_cnt), .active(active),
    .addr(mem_rd_addr), .dot(dot), .line(line));

  always_comb begin
    row_bits = glyph_row(mem_rd_data, line);
    pix_nxt  = 1'b0;
    if (active && (mem_rd_data < CODE_W'(NUM_GLYPHS)) &&
        (dot < DOT_W'(GLYPH_W)) && (line < LINE_W'(GLYPH_H))) begin
      pix_nxt = row_bits[DOT_W'(GLYPH_W - 1) - dot];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ovl_q <= 1'b0;
    else        ovl_q <= pix_nxt;
  end

  assign ovl_out = ovl_q;
endmodule

// File: rtl/osd_overlay_chk.sv
module osd_overlay_chk
  import osd_pkg::*;
#(
  parameter int H_W       = 10,
  parameter int V_W       = 9,
  parameter int ADDR_W    = 6,
  parameter int NPOS      = 60,
  parameter int START_COL = 64,
  parameter int X_END     = 244
) (
  input logic              clk,
  input logic              rst_n,
  input logic              h_lead,
  input logic              v_lead,
  input logic [H_W-1:0]    h_cnt,
  input logic [V_W-1:0]    v_cnt,
  input logic [ADDR_W-1:0] mem_rd_addr,
  input logic [CODE_W-1:0] mem_rd_data,
  input logic              ovl_out
);
  localparam logic [H_W-1:0] H_MAX = '1;

  AST_H_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    h_lead |=> (h_cnt == '0)); // R3
  AST_H_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (!h_lead && h_cnt != H_MAX) |=> (h_cnt == $past(h_cnt) + 1'b1)); // R2
  AST_H_SATURATE: assert property (@(posedge clk) disable iff (!rst_n)
    (!h_lead && h_cnt == H_MAX) |=> (h_cnt == H_MAX)); // R9
  AST_V_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    v_lead |=> (v_cnt == '0)); // R2
  AST_V_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!h_lead && !v_lead) |=> $stable(v_cnt)); // R2
  AST_ADDR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_addr < ADDR_W'(NPOS)); // R4
  AST_BLANK_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_data >= CODE_W'(NUM_GLYPHS)) |=> !ovl_out); // R7
  AST_OUT_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    ovl_out |-> ($past(h_cnt) >= H_W'(START_COL) && $past(h_cnt) < H_W'(X_END))); // R8
endmodule

bind osd_overlay_gen osd_overlay_chk #(
  .H_W(H_W), .V_W(V_W), .ADDR_W(ADDR_W), .NPOS(ROWS * COLS),
  .START_COL(START_COL), .X_END(START_COL + COLS * osd_pkg::CELL_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .h_lead(h_lead), .v_lead(v_lead),
  .h_cnt(h_cnt), .v_cnt(v_cnt), .mem_rd_addr(mem_rd_addr),
  .mem_rd_data(mem_rd_data), .ovl_out(ovl_out));

// File: tb/osd_overlay_gen_tb_top.sv
module osd_overlay_gen_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       hsync_in = 1'b0;
  logic       vsync_in = 1'b0;
  logic [5:0] mem_rd_addr;
  logic [5:0] mem_rd_data;
  logic       ovl_out;
  logic [5:0] mem [0:63];

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  bit pre_sync = 1'b1;
  string zone_tag = "";

  // reference model state
  int    m_hs1 = 0, m_hs2 = 0, m_hd = 0;
  int    m_vs1 = 0, m_vs2 = 0, m_vd = 0;
  int    m_h = 1023, m_v = 511;
  bit    m_ovl = 1'b0;
  string m_tag = "R1";

  always #10 clk = ~clk;

  assign mem_rd_data = mem[mem_rd_addr];

  osd_overlay_gen dut_i (
    .clk(clk), .rst_n(rst_n), .hsync_in(hsync_in), .vsync_in(vsync_in),
    .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data), .ovl_out(ovl_out));

  function automatic void eval(input int h, input int v, output int addr,
                               output bit pix, output string tag);
    int col, d, row, l, c;
    addr = 0; pix = 1'b0; tag = "R8";
    if (h >= 64 && h < 244 && v >= 40 && v < 56) begin
      col = (h - 64) / 6; d = (h - 64) % 6;
      row = (v - 40) / 8; l = (v - 40) % 8;
      addr = row * 30 + col;
      c = int'(mem[addr]);
      if (c >= 44) tag = "R7";
      else if (d == 5 || l == 7) tag = "R6";
      else begin
        tag = "R5";
        pix = bit'((((c * 13 + l * l * 3 + 5) % 32) >> (4 - d)) & 1);
      end
    end
  endfunction

  always @(posedge clk or negedge rst_n) begin
    int a; bit p; string t; int hl, vl;
    if (!rst_n) begin
      m_hs1 = 0; m_hs2 = 0; m_hd = 0; m_vs1 = 0; m_vs2 = 0; m_vd = 0;
      m_h = 1023; m_v = 511; m_ovl = 1'b0; m_tag = "R1";
    end else begin
      hl = (m_hs2 == 1 && m_hd == 0) ? 1 : 0;
      vl = (m_vs2 == 1 && m_vd == 0) ? 1 : 0;
      eval(m_h, m_v, a, p, t);
      m_ovl = p;
      m_tag = pre_sync ? "R1" : (zone_tag != "" ? zone_tag : t);
      if (hl == 1) m_h = 0; else if (m_h < 1023) m_h = m_h + 1;
      if (vl == 1) m_v = 0; else if (hl == 1 && m_v < 511) m_v = m_v + 1;
      m_hd = m_hs2; m_hs2 = m_hs1; m_hs1 = int'(hsync_in);
      m_vd = m_vs2; m_vs2 = m_vs1; m_vs1 = int'(vsync_in);
    end
  end

  always @(negedge clk) begin
    int a; bit p; string t; string at;
    if (!done) begin
      eval(m_h, m_v, a, p, t);
      at = !rst_n ? "R1" : (pre_sync ? "R1" : (zone_tag != "" ? zone_tag : "R4"));
      checks++;
      if (ovl_out !== m_ovl) begin
        failures++;
        $display("FAIL %s ovl_out actual=%b expected=%b t=%0t", m_tag, ovl_out, m_ovl, $time);
      end
      checks++;
      if (mem_rd_addr !== 6'(a)) begin
        failures++;
        $display("FAIL %s mem_rd_addr actual=%0d expected=%0d t=%0t", at, mem_rd_addr, a, $time);
      end
    end
  end

  task automatic drive_line(input int len, input bit vs);
    hsync_in = 1'b1;
    vsync_in = vs;
    for (int i = 0; i < len; i++) begin
      if (i == 20) hsync_in = 1'b0;
      @(negedge clk);
    end
  endtask

  // 62-line field; line "special" gets length special_len and tag ztag (R3/R9 zones)
  task automatic drive_frame(input int special, input int special_len, input string ztag);
    for (int l = 0; l < 62; l++) begin
      if (l == special) zone_tag = ztag;
      if (l == special + 2) zone_tag = "";
      drive_line((l == special) ? special_len : 300, l < 3);
    end
    zone_tag = "";
  endtask

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = 6'(i);
    repeat (10) @(negedge clk);            // R1: outputs checked during reset
    rst_n = 1'b1;
    repeat (50) @(negedge clk);            // R1: no sync seen yet
    pre_sync = 1'b0;
    drive_frame(-10, 300, "");             // R5 R6 R7 R8: codes equal to position
    for (int i = 0; i < 64; i++) mem[i] = 6'($urandom % 64);
    drive_frame(-10, 300, "");             // R5 R7: random codes
    for (int i = 0; i < 64; i++) mem[i] = (i % 2 == 0) ? 6'd43 : 6'd0;
    drive_frame(45, 150, "R3");            // R3: early hsync inside the window
    for (int i = 0; i < 64; i++) mem[i] = 6'(63 - i);
    drive_frame(50, 1400, "R9");           // R9: stretched line saturates
    repeat (20) @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    done = 1'b1;
    checks++;
    failures++;
    $display("FAIL watchdog run did not complete actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule